// File: doc/BRIEF.md
# Serial-Loaded Bank Window Register

This block holds the base address of a 32 KB window through which a small 8-bit coprocessor reaches a 24-bit main address space. Software moves the window by writing one bit at a time. Each write shifts the stored base one place toward the least significant end, and the written bit enters at the most significant position. Only address bits 23 down to 15 are ever stored. The bits below the window granularity always read as zero.

The block also forms the full main-bus address for a coprocessor access. It combines the current base with the 15-bit offset that the coprocessor presents inside the window. Nine writes, least significant bit first, place the window anywhere in the 16 MB space. Main-bus cycles themselves are handled elsewhere.

The reset is asynchronous and active low. Its release is synchronised inside the block, so the first write is taken two clock cycles after the reset input rises.

Top module: `bank_window_reg`

## Requirements
- R1: After reset the base output is 0x000000, so the default window spans 0x000000 to 0x007FFF.
- R2: A rising edge of the write strobe shifts the stored base right by one place and puts the written bit at base bit 23; the change appears on the base output after the clock edge that samples the strobe.
- R3: Only bit 0 of the 8-bit write data is used; bits 7..1 have no effect on the base.
- R4: Base bits 14..0 read as zero at all times.
- R5: Holding the strobe high over several cycles shifts the base only once.
- R6: Nine writes carrying bits b0..b8, least significant first, leave base bits 23..15 equal to b8..b0 (for example, the nine-bit value 0x1A5 gives base 0xD28000).
- R7: The bus address output equals the base ORed with the 15-bit window offset, and it follows the offset input in the same cycle.
- R8: With the strobe low, the base holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe; a rising edge loads one bit |
| wr_data | input | 8 | Write data; only bit 0 is used |
| win_off | input | 15 | Coprocessor offset inside the window |
| base_addr | output | 24 | Current window base |
| bus_addr | output | 24 | Translated main-bus address |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 15-bit window and 8-bit write data. With these values, nine single-bit writes reach any window in the 16 MB space. The stimulus covers the all-ones and alternating base patterns, a strobe held high for several cycles, and write data whose upper bits contradict bit 0. It also uses the extreme offsets 0x0000 and 0x7FFF, so the OR join is exercised on both sides of the window boundary.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;
  localparam int unsigned DEF_ADDR_W = 24;
  localparam int unsigned DEF_WIN_W  = 15;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/bw_rst_sync.sv
module bw_rst_sync #(
  parameter int unsigned DEPTH = bank_window_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[DEPTH-1];
endmodule

// File: rtl/bw_edge_detect.sv
module bw_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/bw_shift_field.sv
module bw_shift_field #(
  parameter int unsigned FIELD_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FIELD_W-1:0] field_o
);
  logic [FIELD_W-1:0] field_q;
  logic [FIELD_W-1:0] field_d;

  always_comb begin
    field_d = field_q;
    if (shift_en) begin
      field_d = {bit_in, field_q[FIELD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= '0;
    else        field_q <= field_d;
  end

  assign field_o = field_q;
endmodule

// File: rtl/bw_addr_join.sv
module bw_addr_join #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WIN_W  = 15
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [WIN_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < WIN_W) begin : g_low
      assign addr_o[i] = base_i[i] | off_i[i];
    end else begin : g_high
      assign addr_o[i] = base_i[i];
    end
  end
endmodule

// File: rtl/bank_window_reg.sv
module bank_window_reg #(
  parameter int unsigned ADDR_W = bank_window_pkg::DEF_ADDR_W,
  parameter int unsigned WIN_W  = bank_window_pkg::DEF_WIN_W,
  parameter int unsigned DATA_W = bank_window_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WIN_W-1:0]  win_off,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam int unsigned FIELD_W = ADDR_W - WIN_W;

  logic               rst_q_n;
  logic               load_pulse;
  logic [FIELD_W-1:0] field;

  bw_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bw_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .level_i (wr_stb),
    .rise_o  (load_pulse)
  );

  bw_shift_field #(.FIELD_W(FIELD_W)) u_field (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .shift_en (load_pulse),
    .bit_in   (wr_data[0]),
    .field_o  (field)
  );

  assign base_addr = {field, {WIN_W{1'b0}}};

  bw_addr_join #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_join (
    .base_i (base_addr),
    .off_i  (win_off),
    .addr_o (bus_addr)
  );
endmodule

// File: rtl/bank_window_chk.sv
module bank_window_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WIN_W  = 15,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ok,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] base_addr
);
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ok) |-> base_addr == '0);

  a_r2_top_bit: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && wr_stb && !$past(wr_stb)) |=> base_addr[ADDR_W-1] == $past(wr_data[0]));

  a_r2_shift_down: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && wr_stb && !$past(wr_stb))
      |=> base_addr[ADDR_W-2:WIN_W] == $past(base_addr[ADDR_W-1:WIN_W+1]));

  a_r5_hold_once: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && wr_stb && $past(wr_stb)) |=> $stable(base_addr));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_stb |=> $stable(base_addr));
endmodule

bind bank_window_reg bank_window_chk #(
  .ADDR_W (ADDR_W),
  .WIN_W  (WIN_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ok    (rst_q_n),
  .wr_stb    (wr_stb),
  .wr_data   (wr_data),
  .base_addr (base_addr)
);

// File: tb/bank_window_reg_test.sv
module bank_window_reg_test;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned WIN_W  = 15;
  localparam int unsigned DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_stb;
  logic [DATA_W-1:0] wr_data;
  logic [WIN_W-1:0]  win_off;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] bus_addr;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  logic [ADDR_W-1:0] q_exp[$];
  string             q_tag[$];
  logic [ADDR_W-1:0] model;

  always #2.5 clk = ~clk;

  bank_window_reg uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .win_off   (win_off),
    .base_addr (base_addr),
    .bus_addr  (bus_addr)
  );

  // monitor: pop and compare, away from the clock edge
  initial begin
    forever begin
      wait (q_exp.size() > 0);
      #1;
      begin
        logic [ADDR_W-1:0] e;
        logic [ADDR_W-1:0] ea;
        string t;
        e  = q_exp.pop_front();
        t  = q_tag.pop_front();
        ea = e | {{(ADDR_W-WIN_W){1'b0}}, win_off};
        n_cmp++;
        if (base_addr !== e) begin
          n_bad++;
          $display("FAIL %s base actual=%h expected=%h", t, base_addr, e);
        end
        n_cmp++;
        if (bus_addr !== ea) begin
          n_bad++;
          $display("FAIL R7 bus actual=%h expected=%h", bus_addr, ea);
        end
        n_cmp++;
        if (base_addr[WIN_W-1:0] !== '0) begin
          n_bad++;
          $display("FAIL R4 low bits actual=%h expected=0", base_addr[WIN_W-1:0]);
        end
      end
    end
  end

  task automatic push(input logic [ADDR_W-1:0] e, input string t);
    q_exp.push_back(e);
    q_tag.push_back(t);
    wait (q_exp.size() == 0);
    #2;
  endtask

  task automatic do_write(input logic [DATA_W-1:0] d, input int hold, input string t);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    repeat (hold) @(negedge clk);
    wr_stb  = 1'b0;
    wr_data = ~d;
    model = ((model >> 1) | (ADDR_W'(d[0]) << (ADDR_W-1))) & ~((ADDR_W'(1) << WIN_W) - 1);
    push(model, t);
  endtask

  task automatic load9(input logic [8:0] v, input string t);
    for (int i = 0; i < 9; i++) do_write({7'd0, v[i]}, 1, t);
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_stb  = 1'b0;
    wr_data = '0;
    win_off = 15'h1234;
    model   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push(24'h000000, "R1");

    do_write(8'h01, 1, "R2");           // 0x800000
    push(24'h800000, "R2");
    do_write(8'h00, 1, "R2");           // 0x400000
    push(24'h400000, "R2");

    do_write(8'hFE, 1, "R3");           // bit0=0 despite upper ones
    do_write(8'h03, 1, "R3");
    do_write(8'h80, 1, "R3");

    do_write(8'h01, 4, "R5");           // held four cycles, one shift
    repeat (3) @(negedge clk);
    push(model, "R5");

    win_off = 15'h0000;
    load9(9'h1A5, "R6");
    push(24'hD28000, "R6");
    win_off = 15'h7FFF;
    push(24'hD28000, "R7");
    load9(9'h1FF, "R6");
    push(24'hFF8000, "R6");
    win_off = 15'h2AAA;
    load9(9'h155, "R6");
    push(24'hAA8000, "R6");

    wr_data = 8'hFF;
    repeat (6) @(negedge clk);
    push(24'hAA8000, "R8");             // strobe low, data toggled: no change

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    repeat (4) @(negedge clk);
    push(24'h000000, "R1");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule